// File: doc/BRIEF.md
# Zero-Line Aware Data Cache

This block is a small cache that treats all-zero lines as a special case. Lines holding any non-zero word sit in a direct-mapped data array with tag, data and a dirty bit. Lines whose words are all zero take no data storage. Only their line address is kept, in a small ternary-match tag store (the null store), where each entry holds a value and a care mask. A new zero-line address is folded into an existing exact entry when the two differ in a single line-address bit. The folded entry then covers both lines, with that bit marked don't-care.

Each accepted request probes both structures in the same cycle. A null-store hit answers with zeros and the same latency as a data-array hit. A miss in both fetches the whole line from memory in one beat. Every refilled line and every line changed by a store is checked for all-zero content and placed in the matching structure, and a line is never held in both. Dirty data lines are written back when they are evicted. Null entries are dropped without any traffic, because their contents are known to be zero. A store that leaves a line all zero sends a zero line to memory at once, so memory always agrees with a dropped null entry. The CPU port carries word addresses. The memory port carries line addresses and full lines, with word w at bits [32w+31:32w].

Top module: `zl_cache`

## Requirements
- R1: After reset, resp_valid, mem_rd_req and mem_wb_valid are low, req_ready is high and all three counters read zero.
- R2: A request that hits the data array gives resp_valid one cycle after acceptance. A read returns the stored word, a store updates the word and marks the line dirty, and every store response carries zero data.
- R3: A read that hits the null store returns zero with the same one-cycle latency as a data-array hit.
- R4: A request that misses both structures raises mem_rd_req for one cycle, one cycle after acceptance, with mem_rd_addr equal to the word address shifted right by 3. req_ready stays low until the refill beat, and resp_valid follows one cycle after mem_rd_valid.
- R5: A refilled line that is all zero enters only the null store. The data line at the same index stays resident, and no write-back occurs.
- R6: A null entry matches any line address that agrees with its value on its cared bits. A zero line inserted next to an exact entry that differs from it in exactly one bit merges into that entry, and the merged entry matches both lines. A line is never present in both structures.
- R7: A non-zero store to a line covered by the null store removes every matching null entry and allocates the line in the data array as dirty, with the other words zero and no refill.
- R8: A zero store to a line covered by the null store changes no state, issues no write-back or refill, and counts as a null hit.
- R9: A store that leaves a data line all zero writes a zero line to memory in that response cycle, frees the data slot and enters the line in the null store.
- R10: An allocation that evicts a dirty data line issues mem_wb_valid with the victim's line address and data in the same cycle as the response. Clean victims and dropped null entries cause no write-back.
- R11: A null insert that does not merge goes to a round-robin slot among the 8 entries, and the pointer advances on each such insert whether or not the slot was valid.
- R12: A store miss refills the line and merges the store word into it. A non-zero result is allocated dirty. A zero result enters the null store, with a zero write-back only if the refilled line was non-zero.
- R13: Each accepted request adds one to exactly one counter: data_hits, null_hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 32 | Load data (zero for stores) |
| mem_rd_req | output | 1 | Refill request strobe |
| mem_rd_addr | output | 9 | Refill line address |
| mem_rd_valid | input | 1 | Refill line present |
| mem_rd_data | input | 256 | Refill line |
| mem_wb_valid | output | 1 | Write-back strobe |
| mem_wb_addr | output | 9 | Write-back line address |
| mem_wb_data | output | 256 | Write-back line |
| data_hits | output | 16 | Data-array hit count |
| null_hits | output | 16 | Null-store hit count |
| misses | output | 16 | Miss count |

## Verification
A non-zero store to a line held in the null store must, in one cycle, remove the null entry and allocate a data slot. When that slot already holds a dirty line from another address, the eviction write-back falls in the same cycle. The bench first dirties a line at one index, then reads a zero line mapping to the same index, then stores a non-zero word to it. It checks that the response, the victim's write-back address and data, and a later data hit on the stored word all agree with the reference model. The same per-clock comparison also covers a store that zeroes a line, where the zero write-back and a null insert or merge happen together.

// File: rtl/zl_cache.sv
module zl_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS = 16,
  parameter int NULL_ENTRIES = 8,
  parameter int CNT_W = 16,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int LA_W = ADDR_W - OFF_W,
  localparam int TAG_W = LA_W - IDX_W,
  localparam int LINE_W = DATA_W * LINE_WORDS,
  localparam int NP_W = $clog2(NULL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic [LA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wb_valid,
  output logic [LA_W-1:0]   mem_wb_addr,
  output logic [LINE_W-1:0] mem_wb_data,
  output logic [CNT_W-1:0]  data_hits,
  output logic [CNT_W-1:0]  null_hits,
  output logic [CNT_W-1:0]  misses
);

  logic [SETS-1:0]   d_valid, d_dirty;
  logic [TAG_W-1:0]  d_tag  [SETS];
  logic [LINE_W-1:0] d_data [SETS];
  logic [NULL_ENTRIES-1:0] n_valid;
  logic [LA_W-1:0]   n_val  [NULL_ENTRIES];
  logic [LA_W-1:0]   n_care [NULL_ENTRIES];
  logic [NP_W-1:0]   rr;

  logic              waiting;
  logic [ADDR_W-1:0] p_addr;
  logic              p_we;
  logic [DATA_W-1:0] p_wdata;

  logic [ADDR_W-1:0] c_addr;
  logic              c_we;
  logic [DATA_W-1:0] c_wdata;
  logic [LA_W-1:0]   c_la;
  logic [OFF_W-1:0]  c_off;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag;

  assign req_ready = !waiting;
  assign c_addr  = waiting ? p_addr  : req_addr;
  assign c_we    = waiting ? p_we    : req_we;
  assign c_wdata = waiting ? p_wdata : req_wdata;
  assign c_la    = c_addr[ADDR_W-1:OFF_W];
  assign c_off   = c_addr[OFF_W-1:0];
  assign c_idx   = c_la[IDX_W-1:0];
  assign c_tag   = c_la[LA_W-1:IDX_W];

  logic d_hit, n_hit, m_any;
  logic [NULL_ENTRIES-1:0] n_match, m_match;
  logic [NP_W-1:0] m_sel;

  assign d_hit = d_valid[c_idx] && (d_tag[c_idx] == c_tag);

  for (genvar g = 0; g < NULL_ENTRIES; g++) begin : g_probe
    assign n_match[g] = n_valid[g] && (((n_val[g] ^ c_la) & n_care[g]) == '0);
    assign m_match[g] = n_valid[g] && (&n_care[g]) && ($countones(n_val[g] ^ c_la) == 1);
  end
  assign n_hit = |n_match;

  always_comb begin
    m_any = 1'b0;
    m_sel = '0;
    for (int i = NULL_ENTRIES - 1; i >= 0; i--)
      if (m_match[i]) begin
        m_any = 1'b1;
        m_sel = NP_W'(i);
      end
  end

  logic [LINE_W-1:0] src_line, wr_line;
  logic wr_zero;
  int unsigned off_bit;
  assign off_bit  = 32'(c_off) * DATA_W;
  assign src_line = waiting ? mem_rd_data : (d_hit ? d_data[c_idx] : '0);
  always_comb begin
    wr_line = src_line;
    if (c_we) wr_line[off_bit +: DATA_W] = c_wdata;
  end
  assign wr_zero = (wr_line == '0);

  logic accept, fill;
  assign accept = !waiting && req_valid;
  assign fill   = waiting && mem_rd_valid;

  logic do_resp, start_miss, do_null_ins, do_dalloc, alloc_dirty;
  logic do_dupdate, do_dinval, do_nremove, do_wb_zero, victim_wb;
  logic cnt_d, cnt_n;
  logic [DATA_W-1:0] resp_word;

  always_comb begin
    do_resp = 1'b0; start_miss = 1'b0; do_null_ins = 1'b0; do_dalloc = 1'b0;
    alloc_dirty = 1'b0; do_dupdate = 1'b0; do_dinval = 1'b0; do_nremove = 1'b0;
    do_wb_zero = 1'b0; cnt_d = 1'b0; cnt_n = 1'b0;
    resp_word = '0;
    if (accept) begin
      if (d_hit) begin
        do_resp = 1'b1;
        cnt_d = 1'b1;
        if (!c_we) resp_word = d_data[c_idx][off_bit +: DATA_W];
        else if (wr_zero) begin
          do_dinval = 1'b1;
          do_null_ins = 1'b1;
          do_wb_zero = 1'b1;
        end else do_dupdate = 1'b1;
      end else if (n_hit) begin
        do_resp = 1'b1;
        cnt_n = 1'b1;
        if (c_we && c_wdata != '0) begin
          do_nremove = 1'b1;
          do_dalloc = 1'b1;
          alloc_dirty = 1'b1;
        end
      end else start_miss = 1'b1;
    end
    if (fill) begin
      do_resp = 1'b1;
      if (!c_we) resp_word = mem_rd_data[off_bit +: DATA_W];
      if (wr_zero) begin
        do_null_ins = 1'b1;
        do_wb_zero = c_we && (mem_rd_data != '0);
      end else begin
        do_dalloc = 1'b1;
        alloc_dirty = c_we;
      end
    end
  end

  assign victim_wb = do_dalloc && d_valid[c_idx] && d_dirty[c_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_rd_req <= 1'b0;
      mem_wb_valid <= 1'b0;
      d_valid <= '0;
      d_dirty <= '0;
      n_valid <= '0;
      rr <= '0;
      data_hits <= '0;
      null_hits <= '0;
      misses <= '0;
    end else begin
      resp_valid <= do_resp;
      resp_rdata <= resp_word;
      mem_rd_req <= start_miss;
      mem_wb_valid <= victim_wb || do_wb_zero;
      if (start_miss) waiting <= 1'b1;
      if (fill) waiting <= 1'b0;
      if (do_dupdate) d_dirty[c_idx] <= 1'b1;
      if (do_dinval) begin
        d_valid[c_idx] <= 1'b0;
        d_dirty[c_idx] <= 1'b0;
      end
      if (do_dalloc) begin
        d_valid[c_idx] <= 1'b1;
        d_dirty[c_idx] <= alloc_dirty;
      end
      if (do_nremove) n_valid <= n_valid & ~n_match;
      if (do_null_ins && !m_any) begin
        n_valid[rr] <= 1'b1;
        rr <= (rr == NP_W'(NULL_ENTRIES - 1)) ? '0 : rr + NP_W'(1);
      end
      if (cnt_d) data_hits <= data_hits + CNT_W'(1);
      if (cnt_n) null_hits <= null_hits + CNT_W'(1);
      if (start_miss) misses <= misses + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (start_miss) begin
      mem_rd_addr <= c_la;
      p_addr <= req_addr;
      p_we <= req_we;
      p_wdata <= req_wdata;
    end
    mem_wb_addr <= do_wb_zero ? c_la : {d_tag[c_idx], c_idx};
    mem_wb_data <= do_wb_zero ? '0 : d_data[c_idx];
    if (do_dupdate) d_data[c_idx] <= wr_line;
    if (do_dalloc) begin
      d_tag[c_idx] <= c_tag;
      d_data[c_idx] <= wr_line;
    end
    if (do_null_ins) begin
      if (m_any) begin
        n_val[m_sel]  <= n_val[m_sel] & ~(n_val[m_sel] ^ c_la);
        n_care[m_sel] <= n_care[m_sel] & ~(n_val[m_sel] ^ c_la);
      end else begin
        n_val[rr]  <= c_la;
        n_care[rr] <= '1;
      end
    end
  end

endmodule

// File: rtl/zl_cache_chk.sv
module zl_cache_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             mem_rd_req,
  input logic             mem_rd_valid,
  input logic             d_hit,
  input logic             n_hit,
  input logic [CNT_W-1:0] data_hits,
  input logic [CNT_W-1:0] null_hits,
  input logic [CNT_W-1:0] misses
);

  p_refill_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (!resp_valid && !req_ready));

  p_fill_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !req_ready) |=> resp_valid);

  p_accept_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || mem_rd_req));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_hit && n_hit));

  p_miss_counted_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (misses != $past(misses)) |-> mem_rd_req);

  p_hit_counted_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_hits != $past(data_hits)) || (null_hits != $past(null_hits))) |-> resp_valid);

endmodule

bind zl_cache zl_cache_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
  .d_hit(d_hit), .n_hit(n_hit), .data_hits(data_hits), .null_hits(null_hits),
  .misses(misses)
);

// File: tb/zl_cache_tb.sv
module zl_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, mem_rd_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [255:0] mem_rd_data = '0;
  logic req_ready, resp_valid, mem_rd_req, mem_wb_valid;
  logic [31:0] resp_rdata;
  logic [8:0] mem_rd_addr, mem_wb_addr;
  logic [255:0] mem_wb_data;
  logic [15:0] data_hits, null_hits, misses;

  always #5 clk = ~clk;

  zl_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data),
    .data_hits(data_hits), .null_hits(null_hits), .misses(misses)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [255:0] mem [int];
  bit m_dv [16], m_dy [16];
  int m_dt [16];
  logic [255:0] m_dd [16];
  bit m_nv [8];
  int m_nval [8], m_ncare [8];
  int m_rr = 0;
  int e_dh = 0, e_nh = 0, e_ms = 0;

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mem_line(int la);
    logic [255:0] l;
    if (mem.exists(la)) return mem[la];
    l = '0;
    if ((la & 2) != 0)
      for (int w = 0; w < 8; w++) l[w*32 +: 32] = 32'(la * 16 + w + 1);
    return l;
  endfunction

  function automatic bit null_hit(int la);
    for (int i = 0; i < 8; i++)
      if (m_nv[i] && (((m_nval[i] ^ la) & m_ncare[i]) == 0)) return 1;
    return 0;
  endfunction

  function automatic void null_ins(int la);
    for (int i = 0; i < 8; i++)
      if (m_nv[i] && m_ncare[i] == 'h1ff && $countones(32'(m_nval[i] ^ la)) == 1) begin
        m_ncare[i] = m_ncare[i] & ~(m_nval[i] ^ la);
        m_nval[i] = m_nval[i] & m_ncare[i];
        return;
      end
    m_nv[m_rr] = 1; m_nval[m_rr] = la; m_ncare[m_rr] = 'h1ff;
    m_rr = (m_rr + 1) % 8;
  endfunction

  task automatic alloc(int idx, int tg, logic [255:0] line, bit dirty,
                       inout bit wb, inout int wa, inout logic [255:0] wd);
    if (m_dv[idx] && m_dy[idx]) begin
      wb = 1; wa = m_dt[idx] * 16 + idx; wd = m_dd[idx];
    end
    m_dv[idx] = 1; m_dy[idx] = dirty; m_dt[idx] = tg; m_dd[idx] = line;
  endtask

  task automatic chk_out(string tag, bit rv, logic [31:0] rd, bit wb, int wa, logic [255:0] wd);
    chk(tag, "resp_valid", 256'(resp_valid), 256'(rv));
    if (rv) chk(tag, "resp_rdata", 256'(resp_rdata), 256'(rd));
    chk(tag, "mem_wb_valid", 256'(mem_wb_valid), 256'(wb));
    if (wb) begin
      chk(tag, "mem_wb_addr", 256'(mem_wb_addr), 256'(wa));
      chk(tag, "mem_wb_data", mem_wb_data, wd);
    end
    chk("R13", "data_hits", 256'(data_hits), 256'(e_dh));
    chk("R13", "null_hits", 256'(null_hits), 256'(e_nh));
    chk("R13", "misses", 256'(misses), 256'(e_ms));
  endtask

  task automatic do_op(bit we, int addr, logic [31:0] wdat, string tag);
    int la = addr >> 3, off = addr & 7, idx = la & 15, tg = la >> 4;
    bit miss = 0, wb = 0;
    int wa = 0;
    logic [255:0] wd = '0, line, base = '0;
    logic [31:0] er = '0;
    if (m_dv[idx] && m_dt[idx] == tg) begin
      e_dh++;
      line = m_dd[idx];
      if (!we) er = line[off*32 +: 32];
      else begin
        line[off*32 +: 32] = wdat;
        if (line == '0) begin
          m_dv[idx] = 0; m_dy[idx] = 0; null_ins(la);
          wb = 1; wa = la; wd = '0;
        end else begin
          m_dd[idx] = line; m_dy[idx] = 1;
        end
      end
    end else if (null_hit(la)) begin
      e_nh++;
      if (we && wdat != 0) begin
        for (int i = 0; i < 8; i++)
          if (m_nv[i] && (((m_nval[i] ^ la) & m_ncare[i]) == 0)) m_nv[i] = 0;
        line = '0; line[off*32 +: 32] = wdat;
        alloc(idx, tg, line, 1, wb, wa, wd);
      end
    end else begin
      miss = 1; e_ms++;
      base = mem_line(la); line = base;
      if (we) line[off*32 +: 32] = wdat; else er = base[off*32 +: 32];
      if (line == '0) begin
        null_ins(la);
        if (we && base != '0) begin wb = 1; wa = la; wd = '0; end
      end else alloc(idx, tg, line, we, wb, wa, wd);
    end
    if (wb) mem[wa] = wd;

    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = 12'(addr); req_wdata = wdat;
    @(negedge clk);
    req_valid = 0;
    if (!miss) begin
      chk_out(tag, 1, er, wb, wa, wd);
      chk("R4", "mem_rd_req", 256'(mem_rd_req), 256'(0));
    end else begin
      chk("R4", "mem_rd_req", 256'(mem_rd_req), 256'(1));
      chk("R4", "mem_rd_addr", 256'(mem_rd_addr), 256'(la));
      chk("R4", "req_ready", 256'(req_ready), 256'(0));
      chk("R4", "resp_valid", 256'(resp_valid), 256'(0));
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R4", "resp_valid wait", 256'(resp_valid), 256'(0));
        chk("R4", "mem_wb_valid wait", 256'(mem_wb_valid), 256'(0));
      end
      mem_rd_valid = 1; mem_rd_data = base;
      @(negedge clk);
      mem_rd_valid = 0;
      chk_out(tag, 1, er, wb, wa, wd);
    end
    @(negedge clk);
    chk_out(tag, 0, '0, 0, 0, '0);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [255:0] l7;
    l7 = '0; l7[3*32 +: 32] = 32'h77;
    mem[7] = l7;
    repeat (3) @(negedge clk);
    chk("R1", "resp_valid", 256'(resp_valid), 256'(0));
    chk("R1", "mem_rd_req", 256'(mem_rd_req), 256'(0));
    chk("R1", "mem_wb_valid", 256'(mem_wb_valid), 256'(0));
    chk("R1", "req_ready", 256'(req_ready), 256'(1));
    chk("R1", "counters", 256'({data_hits, null_hits, misses}), 256'(0));
    rst_n = 1;
    @(negedge clk);

    do_op(0, 0*8+3, 0, "R4");
    do_op(0, 1*8+2, 0, "R6");
    do_op(0, 0*8+7, 0, "R3");
    do_op(0, 1*8+0, 0, "R6");
    do_op(0, 2*8+1, 0, "R4");
    do_op(0, 2*8+5, 0, "R2");
    do_op(1, 2*8+5, 32'hDEAD, "R2");
    do_op(0, 2*8+5, 0, "R2");
    do_op(1, 1*8+4, 0, "R8");
    do_op(0, 1*8+4, 0, "R8");
    do_op(1, 1*8+4, 32'h55, "R7");
    do_op(0, 0*8+1, 0, "R6");
    do_op(0, 1*8+4, 0, "R7");
    do_op(0, 17*8, 0, "R5");
    do_op(0, 1*8+4, 0, "R5");
    do_op(0, 18*8+2, 0, "R10");
    do_op(0, 34*8, 0, "R10");
    for (int w = 0; w < 8; w++) do_op(1, 3*8+w, 0, "R9");
    do_op(0, 3*8+4, 0, "R9");
    do_op(0, 19*8+1, 0, "R9");
    do_op(1, 8*8+2, 32'h1234, "R12");
    do_op(1, 12*8+1, 0, "R12");
    do_op(1, 7*8+3, 0, "R12");
    do_op(0, 7*8+3, 0, "R12");
    do_op(0, 24*8+6, 0, "R10");
    do_op(1, 24*8+6, 32'hBEEF, "R10");
    do_op(0, 24*8+6, 0, "R7");
    do_op(0, 72*8, 0, "R11");
    do_op(0, 160*8, 0, "R11");
    do_op(0, 276*8, 0, "R11");
    do_op(0, 336*8, 0, "R11");
    do_op(0, 400*8, 0, "R11");
    do_op(0, 452*8, 0, "R11");
    do_op(0, 485*8, 0, "R11");
    do_op(0, 17*8+1, 0, "R11");
    do_op(0, 0*8+2, 0, "R11");
    do_op(0, 12*8+5, 0, "R11");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule